// File: doc/BRIEF.md
# Threshold-Gated Interrupt Bid Arbiter

Eight serial channels each present an interrupt bid to this block. A bid is formed from a 7-bit priority value supplied by the channel and the channel's own 3-bit index. The block compares all bids in a balanced comparison tree every cycle and keeps the largest one. It raises an active-low interrupt request only when the winning priority is strictly above a programmable 7-bit threshold. When the winner does not clear the threshold, the reported code is forced to zero.

A watchdog-pending input switches the block into an override mode. In that mode only bids from channels flagged as receiver-class compete, and the threshold is ignored. Any nonzero receiver priority then wins a request, even if the threshold is set high. Arbitration never pauses. The registered winner follows the inputs with one cycle of latency, whether or not a host has captured an earlier result.

Top module: `irq_bid_arbiter`

## Requirements
- R1: The bid of channel i is the 10-bit value {priority[6:0], i[2:0]}, with the priority in bits 9:3 and the channel index in bits 2:0. The larger 10-bit value wins, so equal priorities go to the higher channel index.
- R2: With the watchdog input low, the request `irq_n` is driven low (asserted) exactly when the winning priority is strictly greater than `thresh`.
- R3: When no request is raised, `win_code` is 0 and `win_valid` is 0. This includes a winning priority equal to the threshold.
- R4: With the watchdog input high, a channel whose `chan_is_rx` bit is 0 cannot win, whatever its priority.
- R5: With the watchdog input high, `thresh` has no effect. Any receiver-class channel with a nonzero priority produces a request, even with a threshold of 127.
- R6: A priority of zero means no pending interrupt. If every eligible priority is zero, no request is raised in either mode.
- R7: The outputs are registered. A change at the inputs appears on `win_code`, `win_valid` and `irq_n` after the next rising clock edge, and the result is recomputed on every cycle.
- R8: While `rst` is high at a clock edge, the outputs become `irq_n`=1, `win_valid`=0 and `win_code`=0.
- R9: `irq_n` is always the inverse of `win_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_prio | input | 56 | Per-channel priority; channel i in bits [7i+6:7i] |
| chan_is_rx | input | 8 | Per-channel receiver-class flag |
| thresh | input | 7 | Request threshold (unsigned) |
| wdog_pend | input | 1 | Watchdog event pending: receiver-only mode, threshold bypassed |
| irq_n | output | 1 | Interrupt request, active low |
| win_code | output | 10 | Winning bid {priority, channel}, zero when no request |
| win_valid | output | 1 | Winning bid clears the gate |

## Verification
A broken comparison node or tie rule shows up as the wrong channel index or priority in `win_code`, one clock after the conflicting bids are applied. A faulty gate shows as `irq_n` toggling at the threshold boundary or under watchdog mode with a high threshold, also one cycle later. Stale state, such as a register that fails to reload, appears as an old code persisting past the cycle in which new inputs should have taken over.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_CH = 8;
    localparam int PRIO_W = 7;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int BID_W  = PRIO_W + CH_W;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [CH_W-1:0]   chan;
    } bid_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_WDOG   = 1'b1
    } arb_mode_e;

    localparam bid_t BID_NONE = '{prio: '0, chan: '0};

    // Larger full-width value wins; ties on priority favour the higher channel.
    function automatic bid_t bid_max(input bid_t a, input bid_t b);
        logic [BID_W-1:0] av;
        logic [BID_W-1:0] bv;
        av = {a.prio, a.chan};
        bv = {b.prio, b.chan};
        return (av >= bv) ? a : b;
    endfunction

    // Gate decision: threshold in normal mode, any nonzero bid in watchdog mode.
    function automatic logic bid_passes(input arb_mode_e mode,
                                        input logic [PRIO_W-1:0] prio,
                                        input logic [PRIO_W-1:0] thr);
        logic pass;
        if (mode == MODE_WDOG) begin
            pass = (prio != '0);
        end else begin
            pass = (prio > thr);
        end
        return pass;
    endfunction

endpackage

// File: rtl/irq_bid_former.sv
module irq_bid_former
    import irq_arb_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int P_W  = PRIO_W
) (
    input  logic [N_CH*P_W-1:0] prio_flat,
    input  logic [N_CH-1:0]     is_rx,
    input  arb_mode_e           mode,
    output bid_t                bids [N_CH]
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [P_W-1:0] raw_prio;
        logic           eligible;

        assign raw_prio = prio_flat[i*P_W +: P_W];
        // In watchdog mode only receiver-class channels may bid.
        assign eligible = (mode == MODE_NORMAL) || is_rx[i];

        always_comb begin
            bids[i].chan = CH_W'(i);
            bids[i].prio = eligible ? PRIO_W'(raw_prio) : '0;
        end
    end

endmodule

// File: rtl/irq_max_tree.sv
module irq_max_tree
    import irq_arb_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  bid_t leaves [N_CH],
    output bid_t best
);

    localparam int LVLS = $clog2(N_CH);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int WIDTH = N_CH >> l;
        bid_t node [WIDTH];

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < WIDTH; i++) begin : g_in
                assign node[i] = leaves[i];
            end
        end else begin : g_red
            for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
                assign node[i] = bid_max(g_lvl[l-1].node[2*i],
                                         g_lvl[l-1].node[2*i+1]);
            end
        end
    end

    assign best = g_lvl[LVLS].node[0];

endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bid_t              winner,
    input  logic [PRIO_W-1:0] thr,
    input  arb_mode_e         mode,
    output bid_t              code_q,
    output logic              valid_q,
    output logic              req_n_q
);

    logic pass;
    bid_t code_d;

    always_comb begin
        pass   = bid_passes(mode, winner.prio, thr);
        code_d = pass ? winner : BID_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= BID_NONE;
            valid_q <= 1'b0;
            req_n_q <= 1'b1;
        end else begin
            code_q  <= code_d;
            valid_q <= pass;
            req_n_q <= ~pass;
        end
    end

endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
    import irq_arb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH*PRIO_W-1:0] chan_prio,
    input  logic [NUM_CH-1:0]        chan_is_rx,
    input  logic [PRIO_W-1:0]        thresh,
    input  logic                     wdog_pend,
    output logic                     irq_n,
    output logic [BID_W-1:0]         win_code,
    output logic                     win_valid
);

    arb_mode_e mode;
    bid_t      bids [NUM_CH];
    bid_t      best;
    bid_t      code_q;

    assign mode = wdog_pend ? MODE_WDOG : MODE_NORMAL;

    irq_bid_former #(.N_CH(NUM_CH), .P_W(PRIO_W)) u_former (
        .prio_flat (chan_prio),
        .is_rx     (chan_is_rx),
        .mode      (mode),
        .bids      (bids)
    );

    irq_max_tree #(.N_CH(NUM_CH)) u_tree (
        .leaves (bids),
        .best   (best)
    );

    irq_gate_reg u_gate (
        .clk     (clk),
        .rst     (rst),
        .winner  (best),
        .thr     (thresh),
        .mode    (mode),
        .code_q  (code_q),
        .valid_q (win_valid),
        .req_n_q (irq_n)
    );

    assign win_code = {code_q.prio, code_q.chan};

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH-1:0]        chan_is_rx,
    input logic [PRIO_W-1:0]        thresh,
    input logic                     wdog_pend,
    input logic                     irq_n,
    input logic [BID_W-1:0]         win_code,
    input logic                     win_valid
);

    logic [NUM_CH-1:0] rx_d;
    logic [PRIO_W-1:0] thr_d;
    logic              wd_d;

    always_ff @(posedge clk) begin
        rx_d  <= chan_is_rx;
        thr_d <= thresh;
        wd_d  <= wdog_pend;
    end

    // R9
    req_matches_valid_chk: assert property (@(posedge clk) disable iff (rst)
        irq_n == !win_valid);

    // R3
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> (win_code == '0));

    // R6
    valid_nonzero_prio_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_code[BID_W-1:CH_W] != '0));

    // R2
    above_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !wd_d) |-> (win_code[BID_W-1:CH_W] > thr_d));

    // R4
    wdog_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
        (win_valid && wd_d) |-> rx_d[win_code[CH_W-1:0]]);

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (irq_n && !win_valid && win_code == '0));

endmodule

bind irq_bid_arbiter irq_arb_chk u_arb_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_is_rx (chan_is_rx),
    .thresh     (thresh),
    .wdog_pend  (wdog_pend),
    .irq_n      (irq_n),
    .win_code   (win_code),
    .win_valid  (win_valid)
);

// File: tb/test_irq_bid_arbiter.sv
module test_irq_bid_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [55:0] chan_prio = '0;
    logic [7:0]  chan_is_rx = '0;
    logic [6:0]  thresh = '0;
    logic        wdog_pend = 1'b0;
    logic        irq_n;
    logic [9:0]  win_code;
    logic        win_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_bid_arbiter i_irq_bid_arbiter (
        .clk        (clk),
        .rst        (rst),
        .chan_prio  (chan_prio),
        .chan_is_rx (chan_is_rx),
        .thresh     (thresh),
        .wdog_pend  (wdog_pend),
        .irq_n      (irq_n),
        .win_code   (win_code),
        .win_valid  (win_valid)
    );

    localparam int NV = 11;
    // priorities listed channel 7 down to channel 0
    localparam logic [55:0] V_PRIO [NV] = '{
        {7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0},
        {7'd0, 7'd0, 7'd0, 7'd0, 7'd5, 7'd0, 7'd0, 7'd0},
        {7'd0, 7'd0, 7'd0, 7'd0, 7'd5, 7'd0, 7'd0, 7'd0},
        {7'd0, 7'd20, 7'd0, 7'd0, 7'd0, 7'd0, 7'd20, 7'd0},
        {7'd50, 7'd0, 7'd0, 7'd0, 7'd0, 7'd99, 7'd0, 7'd100},
        {7'd0, 7'd0, 7'd0, 7'd2, 7'd0, 7'd0, 7'd0, 7'd100},
        {7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd100},
        {7'd0, 7'd0, 7'd0, 7'd2, 7'd0, 7'd0, 7'd0, 7'd100},
        {7'd0, 7'd0, 7'd127, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0},
        {7'd60, 7'd0, 7'd0, 7'd0, 7'd9, 7'd9, 7'd0, 7'd0},
        {7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd1}
    };
    localparam logic [7:0] V_RX  [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                          8'h10, 8'h10, 8'h10, 8'h00, 8'h0C, 8'hFF};
    localparam logic [6:0] V_THR [NV] = '{7'd0, 7'd4, 7'd5, 7'd0, 7'd10,
                                          7'd127, 7'd0, 7'd127, 7'd126, 7'd127, 7'd127};
    localparam logic       V_WD  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [9:0] V_CODE[NV] = '{10'd0, 10'd43, 10'd0, 10'd166, 10'd800,
                                          10'd20, 10'd0, 10'd0, 10'd1021, 10'd75, 10'd8};
    localparam logic       V_VAL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
                                          1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam string      V_REQ [NV] = '{"R6", "R2", "R3", "R1", "R1",
                                          "R4/R5", "R4", "R3", "R2", "R4", "R5"};

    task automatic check_out(input string req, input logic [9:0] exp_code,
                             input logic exp_valid);
        checks++;
        if (win_code !== exp_code || win_valid !== exp_valid || irq_n !== ~exp_valid) begin
            errors++;
            $display("FAIL %s: code=%0d valid=%b irq_n=%b expected code=%0d valid=%b irq_n=%b",
                     req, win_code, win_valid, irq_n, exp_code, exp_valid, ~exp_valid);
        end
    endtask

    task automatic drive(input logic [55:0] p, input logic [7:0] rx,
                         input logic [6:0] thr, input logic wd);
        chan_prio  = p;
        chan_is_rx = rx;
        thresh     = thr;
        wdog_pend  = wd;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check_out("R8", 10'd0, 1'b0);
        rst = 1'b0;

        // vector table: apply at negedge, result after next posedge (R7 latency)
        for (int v = 0; v < NV; v++) begin
            drive(V_PRIO[v], V_RX[v], V_THR[v], V_WD[v]);
            @(posedge clk);
            @(negedge clk);
            check_out(V_REQ[v], V_CODE[v], V_VAL[v]);
        end

        // R7: output holds until the edge, then follows new inputs
        drive(V_PRIO[8], V_RX[8], V_THR[8], V_WD[8]);
        @(posedge clk);
        @(negedge clk);
        drive(V_PRIO[0], 8'h00, 7'd0, 1'b0);
        #1;
        check_out("R7", 10'd1021, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_out("R7", 10'd0, 1'b0);

        // R5: watchdog with threshold 127, single receiver at priority 1 on ch6
        drive({7'd0, 7'd1, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0, 7'd0}, 8'h40, 7'd127, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_out("R5", 10'd14, 1'b1);

        // R4: leaving watchdog mode lets the big non-receiver bid back in
        drive(V_PRIO[5], V_RX[5], 7'd0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_out("R4", 10'd800, 1'b1);

        // R8: reset with an active winner present
        drive(V_PRIO[8], V_RX[8], V_THR[8], V_WD[8]);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out("R8", 10'd0, 1'b0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_out("R8", 10'd1021, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule